// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles the control-flow outcome of one branch or jump for a pipeline with a single architectural delay slot. It takes the decoded control-transfer kind, the instruction address, the source register value and index, the 16-bit offset, the 26-bit jump index, the floating-point condition bit and the coprocessor-enable flag. One cycle later it reports the address to fetch once the delay slot is done, whether the transfer was taken, a return-address write and a one-cycle kill of the delay-slot instruction.

Three classes are covered. Sign-tested branches come in plain, likely, linking and linking-likely forms. Floating-point condition branches come in plain and likely forms. Absolute jumps come with and without a link. A floating-point branch issued while the coprocessor is disabled becomes an exception request and has no other effect. A linking branch whose source is the link register itself is reported as a bad encoding and has no other effect.

Top module: `bju_resolve`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every output is 0.
- R2: The outputs in cycle t+1 describe the instruction presented in cycle t with `in_vld`=1. After a cycle with `in_vld`=0, or with op code 0 (none) or 15 (reserved), every output is 0.
- R3: Op codes 1, 3, 5 and 7 are taken when `rs_val` is negative as a signed number. Op codes 2, 4, 6 and 8 are taken when `rs_val` is zero or positive.
- R4: For every resolved branch or jump, `redir_vld`=1. A taken conditional branch gives `redir_pc` = pc+4 + (sign-extended offset << 2). A branch that is not taken gives `redir_pc` = pc+8.
- R5: The likely op codes 3, 4, 7, 8, 11 and 12 raise `nullify_ds` for one cycle when they are not taken. When a likely branch is taken, `nullify_ds`=0. Every other op code leaves `nullify_ds` at 0.
- R6: The linking op codes 5, 6, 7, 8 and 14 set `link_we`=1 with `link_data` = pc+8, whether or not the transfer is taken. Every other op code leaves `link_we`=0 and `link_data`=0.
- R7: Op codes 10 and 12 are taken when `fcc` is 1. Op codes 9 and 11 are taken when `fcc` is 0.
- R8: An op code from 9 to 12 with `cop_en`=0 sets `cop_unusable`=1 and leaves `redir_vld`, `taken`, `nullify_ds` and `link_we` at 0. Op codes outside that range ignore `cop_en`.
- R9: Op codes 13 and 14 are always taken. Their `redir_pc` is the top 4 bits of pc+4 joined with `jidx` and two zero bits.
- R10: A linking sign branch (op codes 5 to 8) with `rs_idx`=31 sets `bad_enc`=1 and leaves `link_we`, `redir_vld` and `nullify_ds` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A control-transfer instruction is presented |
| op | input | 4 | Decoded transfer kind, codes 0 to 15 as in the requirements |
| pc | input | 32 | Address of the branch or jump instruction |
| rs_val | input | 32 | Source register value |
| rs_idx | input | 5 | Source register index |
| imm | input | 16 | Branch offset in words |
| jidx | input | 26 | Jump index in words |
| fcc | input | 1 | Floating-point condition bit |
| cop_en | input | 1 | Floating-point coprocessor is enabled |
| redir_vld | output | 1 | `redir_pc` is valid |
| redir_pc | output | 32 | Address to fetch after the delay slot |
| taken | output | 1 | The transfer was taken |
| nullify_ds | output | 1 | Kill the delay-slot instruction |
| link_we | output | 1 | Write the return address into register 31 |
| link_data | output | 32 | Return address |
| cop_unusable | output | 1 | Coprocessor-unusable exception request |
| bad_enc | output | 1 | Illegal linking encoding |

## Verification
A wrong condition or class decode shows in the very next cycle as a `taken` flag or `redir_pc` that does not match the operands. It also shows as a delay-slot kill on the wrong side of the outcome. A wrong sign extension or region splice shows only for offsets with the top bit set, or for addresses whose upper nibble changes across pc+4. For that reason the stimulus includes the backward offsets 0xFFFF and 0x8000 and a jump issued from just below a 256 MB boundary. Suppression faults show in the same next cycle as a link write or redirect leaking out beside `cop_unusable` or `bad_enc`.

// File: rtl/bju_pkg.sv
package bju_pkg;

   typedef enum logic [3:0] {
      OP_NONE      = 4'd0,
      OP_LTZ       = 4'd1,
      OP_GEZ       = 4'd2,
      OP_LTZ_LK    = 4'd3,
      OP_GEZ_LK    = 4'd4,
      OP_LTZ_RA    = 4'd5,
      OP_GEZ_RA    = 4'd6,
      OP_LTZ_RA_LK = 4'd7,
      OP_GEZ_RA_LK = 4'd8,
      OP_FCF       = 4'd9,
      OP_FCT       = 4'd10,
      OP_FCF_LK    = 4'd11,
      OP_FCT_LK    = 4'd12,
      OP_JMP       = 4'd13,
      OP_JMP_RA    = 4'd14,
      OP_RSVD      = 4'd15
   } bju_op_e;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_SIGN = 2'd1,
      CLS_FPU  = 2'd2,
      CLS_JUMP = 2'd3
   } bju_cls_e;

   // sense: sign class -> taken on negative; fpu class -> taken on bit set
   typedef struct packed {
      bju_cls_e cls;
      logic     sense;
      logic     link;
      logic     likely;
   } bju_attr_t;

   function automatic bju_attr_t bju_decode(input logic [3:0] code);
      bju_attr_t a;
      a = '{cls: CLS_NONE, sense: 1'b0, link: 1'b0, likely: 1'b0};
      case (code)
         OP_LTZ:       a = '{CLS_SIGN, 1'b1, 1'b0, 1'b0};
         OP_GEZ:       a = '{CLS_SIGN, 1'b0, 1'b0, 1'b0};
         OP_LTZ_LK:    a = '{CLS_SIGN, 1'b1, 1'b0, 1'b1};
         OP_GEZ_LK:    a = '{CLS_SIGN, 1'b0, 1'b0, 1'b1};
         OP_LTZ_RA:    a = '{CLS_SIGN, 1'b1, 1'b1, 1'b0};
         OP_GEZ_RA:    a = '{CLS_SIGN, 1'b0, 1'b1, 1'b0};
         OP_LTZ_RA_LK: a = '{CLS_SIGN, 1'b1, 1'b1, 1'b1};
         OP_GEZ_RA_LK: a = '{CLS_SIGN, 1'b0, 1'b1, 1'b1};
         OP_FCF:       a = '{CLS_FPU,  1'b0, 1'b0, 1'b0};
         OP_FCT:       a = '{CLS_FPU,  1'b1, 1'b0, 1'b0};
         OP_FCF_LK:    a = '{CLS_FPU,  1'b0, 1'b0, 1'b1};
         OP_FCT_LK:    a = '{CLS_FPU,  1'b1, 1'b0, 1'b1};
         OP_JMP:       a = '{CLS_JUMP, 1'b0, 1'b0, 1'b0};
         OP_JMP_RA:    a = '{CLS_JUMP, 1'b0, 1'b1, 1'b0};
         default:      a = '{CLS_NONE, 1'b0, 1'b0, 1'b0};
      endcase
      return a;
   endfunction

endpackage

// File: rtl/bju_cond.sv
module bju_cond
   import bju_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  bju_cls_e          cls,
   input  logic              sense,
   input  logic [XLEN-1:0]   rs_val,
   input  logic              fcc,
   output logic              cond
);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("bju_cond: XLEN must be at least 8");
      end
   endgenerate

   logic rs_neg;

   assign rs_neg = ($signed(rs_val) < 0);

   always_comb begin
      case (cls)
         CLS_SIGN: cond = (rs_neg == sense);
         CLS_FPU:  cond = (fcc == sense);
         CLS_JUMP: cond = 1'b1;
         default:  cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/bju_target.sv
module bju_target #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16,
   parameter int IDX_W = 26
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [IMM_W-1:0] imm,
   input  logic [IDX_W-1:0] jidx,
   output logic [XLEN-1:0]  pc_seq,
   output logic [XLEN-1:0]  br_tgt,
   output logic [XLEN-1:0]  jmp_tgt
);

   localparam int EXT_W    = XLEN - IMM_W - 2;
   localparam int REGION_W = XLEN - IDX_W - 2;

   generate
      if (EXT_W < 0) begin : g_bad_imm
         $error("bju_target: IMM_W too wide for XLEN");
      end
      if (REGION_W < 0) begin : g_bad_idx
         $error("bju_target: IDX_W too wide for XLEN");
      end
   endgenerate

   logic [XLEN-1:0] pc_ds;
   logic [XLEN-1:0] offs;

   assign pc_ds  = pc + XLEN'(4);
   assign pc_seq = pc + XLEN'(8);

   generate
      if (EXT_W > 0) begin : g_ext
         assign offs = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
      end else begin : g_noext
         assign offs = {imm, 2'b00};
      end
   endgenerate

   assign br_tgt = pc_ds + offs;

   generate
      if (REGION_W > 0) begin : g_region
         assign jmp_tgt = {pc_ds[XLEN-1 -: REGION_W], jidx, 2'b00};
      end else begin : g_noregion
         assign jmp_tgt = {jidx, 2'b00};
      end
   endgenerate

endmodule

// File: rtl/bju_ctl.sv
module bju_ctl
   import bju_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int RIDX_W   = 5,
   parameter int LINK_REG = 31
) (
   input  logic              vld,
   input  bju_attr_t         attr,
   input  logic              cond,
   input  logic              cop_en,
   input  logic [RIDX_W-1:0] rs_idx,
   input  logic [XLEN-1:0]   pc_seq,
   input  logic [XLEN-1:0]   br_tgt,
   input  logic [XLEN-1:0]   jmp_tgt,
   output logic              redir_vld,
   output logic [XLEN-1:0]   redir_pc,
   output logic              taken,
   output logic              nullify,
   output logic              link_we,
   output logic [XLEN-1:0]   link_data,
   output logic              cop_exc,
   output logic              bad_enc
);

   generate
      if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_link
         $error("bju_ctl: LINK_REG does not fit in RIDX_W bits");
      end
   endgenerate

   logic active;
   logic go;

   assign active  = vld && (attr.cls != CLS_NONE);
   assign cop_exc = active && (attr.cls == CLS_FPU) && !cop_en;
   assign bad_enc = active && attr.link && (attr.cls == CLS_SIGN)
                    && (rs_idx == RIDX_W'(LINK_REG));
   assign go      = active && !cop_exc && !bad_enc;

   assign redir_vld = go;
   assign taken     = go && cond;
   assign nullify   = go && attr.likely && !cond;
   assign link_we   = go && attr.link;
   assign link_data = link_we ? pc_seq : '0;

   always_comb begin
      if (!go)
         redir_pc = '0;
      else if (!cond)
         redir_pc = pc_seq;
      else if (attr.cls == CLS_JUMP)
         redir_pc = jmp_tgt;
      else
         redir_pc = br_tgt;
   end

endmodule

// File: rtl/bju_resolve.sv
module bju_resolve
   import bju_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IMM_W    = 16,
   parameter int IDX_W    = 26,
   parameter int RIDX_W   = 5,
   parameter int LINK_REG = 31,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [3:0]        op,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [RIDX_W-1:0] rs_idx,
   input  logic [IMM_W-1:0]  imm,
   input  logic [IDX_W-1:0]  jidx,
   input  logic              fcc,
   input  logic              cop_en,
   output logic              redir_vld,
   output logic [XLEN-1:0]   redir_pc,
   output logic              taken,
   output logic              nullify_ds,
   output logic              link_we,
   output logic [XLEN-1:0]   link_data,
   output logic              cop_unusable,
   output logic              bad_enc
);

   bju_attr_t       attr;
   logic            cond;
   logic [XLEN-1:0] pc_seq, br_tgt, jmp_tgt;

   logic            c_rv, c_tk, c_nul, c_lwe, c_cop, c_bad;
   logic [XLEN-1:0] c_rpc, c_ldat;

   assign attr = bju_decode(op);

   bju_cond #(.XLEN(XLEN)) i_cond (
      .cls    (attr.cls),
      .sense  (attr.sense),
      .rs_val (rs_val),
      .fcc    (fcc),
      .cond   (cond)
   );

   bju_target #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) i_target (
      .pc      (pc),
      .imm     (imm),
      .jidx    (jidx),
      .pc_seq  (pc_seq),
      .br_tgt  (br_tgt),
      .jmp_tgt (jmp_tgt)
   );

   bju_ctl #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) i_ctl (
      .vld       (in_vld),
      .attr      (attr),
      .cond      (cond),
      .cop_en    (cop_en),
      .rs_idx    (rs_idx),
      .pc_seq    (pc_seq),
      .br_tgt    (br_tgt),
      .jmp_tgt   (jmp_tgt),
      .redir_vld (c_rv),
      .redir_pc  (c_rpc),
      .taken     (c_tk),
      .nullify   (c_nul),
      .link_we   (c_lwe),
      .link_data (c_ldat),
      .cop_exc   (c_cop),
      .bad_enc   (c_bad)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               redir_vld    <= 1'b0;
               redir_pc     <= '0;
               taken        <= 1'b0;
               nullify_ds   <= 1'b0;
               link_we      <= 1'b0;
               link_data    <= '0;
               cop_unusable <= 1'b0;
               bad_enc      <= 1'b0;
            end else begin
               redir_vld    <= c_rv;
               redir_pc     <= c_rpc;
               taken        <= c_tk;
               nullify_ds   <= c_nul;
               link_we      <= c_lwe;
               link_data    <= c_ldat;
               cop_unusable <= c_cop;
               bad_enc      <= c_bad;
            end
         end

         // R8
         cop_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cop_unusable |-> !(redir_vld || link_we || nullify_ds || taken));

         // R10
         bad_enc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bad_enc |-> !(link_we || redir_vld || nullify_ds));

         // R5
         nullify_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nullify_ds |-> (redir_vld && !taken));

         // R4
         miss_seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (redir_vld && !taken) |-> (redir_pc == $past(pc) + XLEN'(8)));

         // R6
         link_ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            link_we |-> (link_data == $past(pc) + XLEN'(8)));

         // R2
         result_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (redir_vld || cop_unusable || bad_enc) |-> $past(in_vld));

         // R2
         one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({redir_vld, cop_unusable, bad_enc}));
      end else begin : g_comb
         assign redir_vld    = c_rv;
         assign redir_pc     = c_rpc;
         assign taken        = c_tk;
         assign nullify_ds   = c_nul;
         assign link_we      = c_lwe;
         assign link_data    = c_ldat;
         assign cop_unusable = c_cop;
         assign bad_enc      = c_bad;
      end
   endgenerate

endmodule

// File: tb/test_bju_resolve.sv
`timescale 1ns/1ps
module test_bju_resolve;

   typedef struct packed {
      logic        rv;
      logic [31:0] rpc;
      logic        tk;
      logic        nul;
      logic        lwe;
      logic [31:0] ldat;
      logic        cop;
      logic        bad;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [31:0] pc = '0, rs_val = '0;
   logic [4:0]  rs_idx = '0;
   logic [15:0] imm = '0;
   logic [25:0] jidx = '0;
   logic        fcc = 1'b0, cop_en = 1'b1;

   logic        redir_vld, taken, nullify_ds, link_we, cop_unusable, bad_enc;
   logic [31:0] redir_pc, link_data;

   int errors = 0;
   int checks = 0;

   exp_t  exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   bju_resolve i_bju_resolve (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .pc(pc),
      .rs_val(rs_val), .rs_idx(rs_idx), .imm(imm), .jidx(jidx),
      .fcc(fcc), .cop_en(cop_en),
      .redir_vld(redir_vld), .redir_pc(redir_pc), .taken(taken),
      .nullify_ds(nullify_ds), .link_we(link_we), .link_data(link_data),
      .cop_unusable(cop_unusable), .bad_enc(bad_enc)
   );

   function automatic exp_t model(input logic v, input logic [3:0] o,
                                  input logic [31:0] p, input logic [31:0] r,
                                  input logic [4:0] ri, input logic [15:0] im,
                                  input logic [25:0] ji, input logic fc,
                                  input logic ce);
      exp_t e;
      logic is_sgn, is_fpu, is_j, is_lnk, is_lik, cnd;
      logic [31:0] seq, ds;
      e = '0;
      is_sgn = (o >= 4'd1 && o <= 4'd8);
      is_fpu = (o >= 4'd9 && o <= 4'd12);
      is_j   = (o == 4'd13 || o == 4'd14);
      is_lnk = (o >= 4'd5 && o <= 4'd8) || o == 4'd14;
      is_lik = (o == 4'd3 || o == 4'd4 || o == 4'd7 || o == 4'd8 ||
                o == 4'd11 || o == 4'd12);
      seq = p + 32'd8;
      ds  = p + 32'd4;
      if (!v || !(is_sgn || is_fpu || is_j)) return e;
      if (is_fpu && !ce) begin e.cop = 1'b1; return e; end
      if (is_sgn && is_lnk && ri == 5'd31) begin e.bad = 1'b1; return e; end
      if (is_sgn) cnd = o[0] ? ($signed(r) < 0) : ($signed(r) >= 0);
      else if (is_fpu) cnd = o[0] ? !fc : fc;
      else cnd = 1'b1;
      e.rv  = 1'b1;
      e.tk  = cnd;
      e.nul = is_lik && !cnd;
      e.lwe = is_lnk;
      e.ldat = is_lnk ? seq : 32'd0;
      if (!cnd) e.rpc = seq;
      else if (is_j) e.rpc = {ds[31:28], ji, 2'b00};
      else e.rpc = ds + {{14{im[15]}}, im, 2'b00};
      return e;
   endfunction

   task automatic issue(input logic [3:0] o, input logic [31:0] p,
                        input logic [31:0] r, input logic [4:0] ri,
                        input logic [15:0] im, input logic [25:0] ji,
                        input logic fc, input logic ce, input string tag);
      @(negedge clk);
      in_vld = 1'b1; op = o; pc = p; rs_val = r; rs_idx = ri;
      imm = im; jidx = ji; fcc = fc; cop_en = ce;
      exp_q.push_back(model(1'b1, o, p, r, ri, im, ji, fc, ce));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      in_vld = 1'b0; op = 4'd13; pc = 32'h1234_5678;
      exp_q.push_back('0);
      tag_q.push_back(tag);
   endtask

   // monitor: compares one cycle after each driven cycle
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t  e;
         exp_t  a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = '{redir_vld, redir_pc, taken, nullify_ds, link_we, link_data,
               cop_unusable, bad_enc};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: got rv=%b pc=%h tk=%b nul=%b lwe=%b ld=%h cop=%b bad=%b exp rv=%b pc=%h tk=%b nul=%b lwe=%b ld=%h cop=%b bad=%b",
                     t, a.rv, a.rpc, a.tk, a.nul, a.lwe, a.ldat, a.cop, a.bad,
                     e.rv, e.rpc, e.tk, e.nul, e.lwe, e.ldat, e.cop, e.bad);
         end
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if ({redir_vld, taken, nullify_ds, link_we, cop_unusable, bad_enc} !== 6'b0 ||
          redir_pc !== 32'd0 || link_data !== 32'd0) begin
         errors++;
         $display("FAIL R1: got outputs nonzero during reset exp all zero");
      end
      rst_n = 1'b1;
      #1;
      checks++;
      if ({redir_vld, taken, nullify_ds, link_we, cop_unusable, bad_enc} !== 6'b0) begin
         errors++;
         $display("FAIL R1: got flags nonzero after reset exp zero");
      end

      // R3 / R4 sign conditions and targets
      issue(4'd1, 32'h8000_1000, 32'hFFFF_FFFB, 5'd3, 16'h0010, '0, 0, 1, "R3 ltz neg");
      issue(4'd1, 32'h8000_1000, 32'h0000_0000, 5'd3, 16'h0010, '0, 0, 1, "R3 ltz zero");
      issue(4'd2, 32'h8000_2000, 32'h0000_0000, 5'd3, 16'h0020, '0, 0, 1, "R3 gez zero");
      issue(4'd2, 32'h8000_2000, 32'h8000_0000, 5'd3, 16'h0020, '0, 0, 1, "R3 gez min");
      issue(4'd2, 32'h0040_0100, 32'h0000_0007, 5'd3, 16'hFFFF, '0, 0, 1, "R4 back one");
      issue(4'd2, 32'h0040_0100, 32'h0000_0007, 5'd3, 16'h8000, '0, 0, 1, "R4 back max");
      issue(4'd2, 32'h0040_0100, 32'h0000_0007, 5'd3, 16'h7FFF, '0, 0, 0, "R8 gez ignores cop_en");
      // R5 likely
      issue(4'd3, 32'h8000_3000, 32'h0000_0003, 5'd2, 16'h0040, '0, 0, 1, "R5 likely miss");
      issue(4'd4, 32'h8000_3000, 32'h0000_0003, 5'd2, 16'h0040, '0, 0, 1, "R5 likely hit");
      // R6 link
      issue(4'd6, 32'h8000_4000, 32'hFFFF_FFFF, 5'd4, 16'h0008, '0, 0, 1, "R6 link miss");
      issue(4'd7, 32'h8000_4000, 32'hFFFF_FFFF, 5'd4, 16'h0008, '0, 0, 1, "R6 link likely hit");
      issue(4'd8, 32'h8000_4000, 32'hFFFF_FFFF, 5'd4, 16'h0008, '0, 0, 1, "R6 link likely miss");
      issue(4'd5, 32'h8000_4000, 32'hFFFF_FFFF, 5'd30, 16'h0008, '0, 0, 1, "R6 link r30");
      // R10 bad encoding
      issue(4'd5, 32'h8000_5000, 32'hFFFF_FFFF, 5'd31, 16'h0008, '0, 0, 1, "R10 link rs31");
      issue(4'd8, 32'h8000_5000, 32'h0000_0001, 5'd31, 16'h0008, '0, 0, 1, "R10 link likely rs31");
      // R7 fpu condition
      issue(4'd10, 32'h8000_6000, '0, 5'd0, 16'h0100, '0, 1, 1, "R7 fct set");
      issue(4'd10, 32'h8000_6000, '0, 5'd0, 16'h0100, '0, 0, 1, "R7 fct clear");
      issue(4'd9,  32'h8000_6000, '0, 5'd0, 16'h0100, '0, 0, 1, "R7 fcf clear");
      issue(4'd11, 32'h8000_6000, '0, 5'd0, 16'h0100, '0, 1, 1, "R7 fcf likely miss");
      issue(4'd12, 32'h8000_6000, '0, 5'd0, 16'h0100, '0, 1, 1, "R7 fct likely hit");
      // R8 coprocessor disabled
      issue(4'd12, 32'h8000_7000, '0, 5'd0, 16'h0100, '0, 1, 0, "R8 fct likely off");
      issue(4'd9,  32'h8000_7000, '0, 5'd0, 16'h0100, '0, 0, 0, "R8 fcf off");
      // R9 jumps
      issue(4'd13, 32'h9FFF_FFFC, '0, 5'd0, '0, 26'h012_3456, 0, 1, "R9 jump region");
      issue(4'd14, 32'h0040_0000, '0, 5'd31, '0, 26'h3FF_FFFF, 0, 0, "R9 jump link");
      // R2 empty cycles
      idle("R2 idle");
      issue(4'd0,  32'h8000_8000, 32'hFFFF_FFFF, 5'd1, 16'h0004, 26'h1, 1, 1, "R2 op none");
      issue(4'd15, 32'h8000_8000, 32'hFFFF_FFFF, 5'd1, 16'h0004, 26'h1, 1, 1, "R2 op reserved");
      issue(4'd1,  32'hFFFF_FFF8, 32'hFFFF_FFFF, 5'd1, 16'h0001, '0, 0, 1, "R4 wrap");
      idle("R2 idle end");
      idle("R2 idle end2");
      wait (exp_q.size() == 0);
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule